// File: doc/BRIEF.md
# Striped Multi-Bank SRAM Crossbar

This block is the shared on-chip memory of a multi-master system. Six independent SRAM banks sit behind one flat byte address space. Four of the banks are large and two are small. Several bus masters reach the banks through their own request ports.

Every request is a 32-bit word access. A decoder turns it into a bank number and a word index inside that bank. Three kinds of window are decoded:

- **Interleaved window.** It starts at `BASE`. Consecutive words rotate across the four large banks.
- **Small-bank windows.** Two windows follow the interleaved window. Each one maps linearly onto one small bank.
- **Linear alias.** It starts at `ALIAS`. It lays the four large banks end to end. It reaches the same storage as the interleaved window.

Any bank may hold code or data. No bank is restricted by access type.

Each bank has its own round-robin arbiter. Masters that hit different banks in one cycle are all served in that cycle. Masters that collide on a bank are served one per cycle. A losing master sees its ready held low and keeps its request unchanged until it is granted. Read data comes back one cycle after acceptance.

With `LG_AW=14` and `SM_AW=10`, the map is the full-size one:

| Window | Start address | Size | Target |
|---|---|---|---|
| Interleaved | 0x20000000 | 256 kB | four large banks, word-striped |
| Small bank 0 | 0x20040000 | 4 kB | small bank 0, linear |
| Small bank 1 | 0x20041000 | 4 kB | small bank 1, linear |
| Linear alias | 0x21000000 | 4 x 64 kB | large banks 0 to 3, in order |

The defaults are smaller so that the memories stay small for elaboration.

Top module: `sram_stripe_xbar`

## Requirements
In the requirements below, "offset" means the address minus the start of the window it falls in.

- R1: In the interleaved window (`BASE` up to `BASE + 2^(LG_AW+4)`), offset bits [3:2] select the large bank. Offset bits [LG_AW+3:4] give the word index.
- R2: The two windows that follow the interleaved window are each 2^(SM_AW+2) bytes. The first maps linearly onto small bank 4 and the second onto small bank 5. The word index is offset bits [SM_AW+1:2].
- R3: In the linear alias (`ALIAS` up to `ALIAS + 4*2^(LG_AW+2)`), offset bits [LG_AW+3:LG_AW+2] select large bank 0 to 3, in order. Offset bits [LG_AW+1:2] give the word index. Data written through either the interleaved window or the alias is read back unchanged through the other.
- R4: An address outside every window is accepted in the cycle it is presented. `m_fault` of that master is high for exactly the next cycle, with `m_rdata` zero. No bank is touched.
- R5: A valid request whose bank no other master addresses in that cycle has `m_ready` high in that same cycle.
- R6: Masters that address different banks in one cycle are all accepted in that cycle.
- R7: When several masters address one bank in a cycle, exactly one of them has `m_ready` high. The others have it low.
- R8: Each bank's arbiter starts at master 0 after reset. After granting master m, it favours master m+1 (wrapping) at its next conflict.
- R9: `m_rvalid` is high in the cycle after an accepted read (including a faulted one) and low otherwise. `m_rdata` then carries the addressed word.
- R10: A write changes only the bytes whose `m_be` bit is set. Bit k covers data bits [8k+7:8k].
- R11: `m_ready` is never high while `m_valid` of that master is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | NM | Request valid, one bit per master |
| m_ready | output | NM | Request accepted this cycle, one bit per master |
| m_addr | input | NM*32 | Byte addresses; master m uses bits [32m+31:32m] |
| m_we | input | NM | 1 = write, 0 = read |
| m_be | input | NM*4 | Byte strobes; master m uses bits [4m+3:4m] |
| m_wdata | input | NM*32 | Write data, packed like m_addr |
| m_rvalid | output | NM | Read data valid, one cycle after an accepted read |
| m_rdata | output | NM*32 | Read data, zero when m_rvalid is low or on a fault |
| m_fault | output | NM | Decode fault, one cycle after an accepted out-of-window request |

## Verification
Some properties are checked on every cycle:

- ready is never raised without valid;
- a lone requester is always served;
- two masters on the same interleaved word never both win;
- an accepted read is always followed by read-valid, and read-valid never appears otherwise;
- a fault always returns zero data.

The bank and index mapping, aliasing between the two large-bank views, byte-strobe merging and the round-robin order depend on stored contents and history. Only the bench's scenarios can show these: it compares each response against a reference memory and arbiter model, and runs directed cross-alias write/read pairs and back-to-back conflicts.

// File: rtl/sram_stripe_xbar.sv
`timescale 1ns/1ps
module sram_stripe_xbar #(
  parameter int          NM    = 2,
  parameter int          LG_AW = 9,
  parameter int          SM_AW = 8,
  parameter logic [31:0] BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS = 32'h2100_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_valid,
  output logic [NM-1:0]    m_ready,
  input  logic [NM*32-1:0] m_addr,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*4-1:0]  m_be,
  input  logic [NM*32-1:0] m_wdata,
  output logic [NM-1:0]    m_rvalid,
  output logic [NM*32-1:0] m_rdata,
  output logic [NM-1:0]    m_fault
);
  localparam int NB = 6;
  localparam int IW = LG_AW;
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam logic [31:0] STRIPE_SZ = 32'(1) << (LG_AW + 4);
  localparam logic [31:0] SMALL_SZ  = 32'(1) << (SM_AW + 2);
  localparam logic [31:0] SMALL2_SZ = SMALL_SZ << 1;
  localparam logic [31:0] LBANK_SZ  = 32'(1) << (LG_AW + 2);
  localparam logic [31:0] ALIAS_SZ  = LBANK_SZ << 2;
  localparam logic [31:0] SM_BASE   = BASE + STRIPE_SZ;

  function automatic int wrap(input int v);
    return v % NM;
  endfunction

  logic [NM-1:0] d_hit;
  logic [2:0]    d_bank [NM];
  logic [IW-1:0] d_idx  [NM];

  for (genvar m = 0; m < NM; m++) begin : g_dec
    logic [31:0] a, so, sm, al;
    assign a  = m_addr[m*32 +: 32];
    assign so = a - BASE;
    assign sm = a - SM_BASE;
    assign al = a - ALIAS;
    always_comb begin
      d_hit[m]  = 1'b0;
      d_bank[m] = 3'd0;
      d_idx[m]  = '0;
      if (so < STRIPE_SZ) begin
        d_hit[m]  = 1'b1;
        d_bank[m] = {1'b0, so[3:2]};
        d_idx[m]  = so[LG_AW+3:4];
      end else if (sm < SMALL2_SZ) begin
        d_hit[m]  = 1'b1;
        d_bank[m] = sm[SM_AW+2] ? 3'd5 : 3'd4;
        d_idx[m]  = IW'(sm[SM_AW+1:2]);
      end else if (al < ALIAS_SZ) begin
        d_hit[m]  = 1'b1;
        d_bank[m] = {1'b0, al[LG_AW+3:LG_AW+2]};
        d_idx[m]  = al[LG_AW+1:2];
      end
    end
  end

  logic [MW-1:0] rr   [NB];
  logic [NB-1:0] b_en;
  logic [MW-1:0] b_gm [NB];

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      b_en[b] = 1'b0;
      b_gm[b] = '0;
      for (int k = 0; k < NM; k++) begin
        if (!b_en[b] && m_valid[wrap(int'(rr[b]) + k)] && d_hit[wrap(int'(rr[b]) + k)]
            && d_bank[wrap(int'(rr[b]) + k)] == 3'(b)) begin
          b_en[b] = 1'b1;
          b_gm[b] = MW'(wrap(int'(rr[b]) + k));
        end
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++)
      m_ready[m] = m_valid[m] &&
                   (!d_hit[m] || (b_en[d_bank[m]] && b_gm[d_bank[m]] == MW'(m)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) rr[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++)
        if (b_en[b]) rr[b] <= (b_gm[b] == MW'(NM-1)) ? '0 : b_gm[b] + 1'b1;
    end
  end

  logic          b_we [NB];
  logic [3:0]    b_be [NB];
  logic [IW-1:0] b_ix [NB];
  logic [31:0]   b_wd [NB];
  logic [31:0]   b_rd [NB];

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      b_we[b] = m_we[b_gm[b]];
      b_be[b] = m_be[int'(b_gm[b])*4 +: 4];
      b_wd[b] = m_wdata[int'(b_gm[b])*32 +: 32];
      b_ix[b] = d_idx[b_gm[b]];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int AW  = (b < 4) ? LG_AW : SM_AW;
    localparam int DEP = 1 << AW;
    logic [31:0]   mem [DEP];
    logic [31:0]   rd_q;
    logic [AW-1:0] ix;
    assign ix      = b_ix[b][AW-1:0];
    assign b_rd[b] = rd_q;
    always_ff @(posedge clk) begin
      if (b_en[b]) begin
        if (b_we[b]) begin
          for (int y = 0; y < 4; y++)
            if (b_be[b][y]) mem[ix][y*8 +: 8] <= b_wd[b][y*8 +: 8];
        end else begin
          rd_q <= mem[ix];
        end
      end
    end
  end

  logic [2:0] o_bank [NM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rvalid <= '0;
      m_fault  <= '0;
    end else begin
      for (int m = 0; m < NM; m++) begin
        m_rvalid[m] <= m_valid[m] && m_ready[m] && !m_we[m];
        m_fault[m]  <= m_valid[m] && m_ready[m] && !d_hit[m];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int m = 0; m < NM; m++) o_bank[m] <= d_bank[m];
  end

  for (genvar m = 0; m < NM; m++) begin : g_out
    assign m_rdata[m*32 +: 32] = (m_rvalid[m] && !m_fault[m]) ? b_rd[o_bank[m]] : 32'd0;
  end
endmodule

// File: rtl/sram_stripe_xbar_chk.sv
`timescale 1ns/1ps
module sram_stripe_xbar_chk #(
  parameter int          NM    = 2,
  parameter int          LG_AW = 9,
  parameter logic [31:0] BASE  = 32'h2000_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    m_valid,
  input logic [NM-1:0]    m_ready,
  input logic [NM*32-1:0] m_addr,
  input logic [NM-1:0]    m_we,
  input logic [NM-1:0]    m_rvalid,
  input logic [NM*32-1:0] m_rdata,
  input logic [NM-1:0]    m_fault
);
  localparam logic [31:0] STRIPE_SZ = 32'(1) << (LG_AW + 4);

  for (genvar m = 0; m < NM; m++) begin : g_m
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready[m] |-> m_valid[m]); // R11
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[m] && m_ready[m] && !m_we[m]) |=> m_rvalid[m]); // R9
    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_valid[m] && m_ready[m] && !m_we[m]) |=> !m_rvalid[m]); // R9
    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      m_fault[m] |-> (m_rdata[m*32 +: 32] == 32'd0)); // R4
  end

  AST_LONE_MASTER_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(m_valid) == 1) |-> (m_ready == m_valid)); // R5

  for (genvar i = 0; i < NM; i++) begin : g_pi
    for (genvar j = i + 1; j < NM; j++) begin : g_pj
      AST_SAME_WORD_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid[i] && m_valid[j] && m_addr[i*32+2 +: 30] == m_addr[j*32+2 +: 30]
         && (m_addr[i*32 +: 32] - BASE) < STRIPE_SZ) |-> (m_ready[i] ^ m_ready[j])); // R7
    end
  end
endmodule

bind sram_stripe_xbar sram_stripe_xbar_chk #(.NM(NM), .LG_AW(LG_AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
  .m_we(m_we), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .m_fault(m_fault)
);

// File: tb/sram_stripe_xbar_tb_top.sv
`timescale 1ns/1ps
module sram_stripe_xbar_tb_top;
  localparam logic [31:0] BASE  = 32'h2000_0000;
  localparam logic [31:0] ALIAS = 32'h2100_0000;
  localparam logic [31:0] SM0   = 32'h2000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  m_valid = '0;
  logic [1:0]  m_ready;
  logic [63:0] m_addr = '0;
  logic [1:0]  m_we = '0;
  logic [7:0]  m_be = '0;
  logic [63:0] m_wdata = '0;
  logic [1:0]  m_rvalid;
  logic [63:0] m_rdata;
  logic [1:0]  m_fault;

  always #2 clk = ~clk;

  sram_stripe_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .m_we(m_we), .m_be(m_be), .m_wdata(m_wdata), .m_rvalid(m_rvalid),
    .m_rdata(m_rdata), .m_fault(m_fault)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] mdl [2560];
  int          rr_m [6];
  bit          rq_v [2];
  logic [31:0] rq_a [2];
  bit          rq_we [2];
  logic [3:0]  rq_be [2];
  logic [31:0] rq_wd [2];
  logic [31:0] obs_d [2];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic void bdec(input logic [31:0] a, output bit hit, output int bank, output int idx);
    logic [31:0] off;
    hit = 1; bank = 0; idx = 0;
    if (a >= BASE && a < BASE + 32'h2000) begin
      off = a - BASE; bank = int'(off[31:2]) % 4; idx = int'(off >> 4);
    end else if (a >= SM0 && a < SM0 + 32'h800) begin
      off = a - SM0; bank = (off >= 32'h400) ? 5 : 4; idx = int'(off % 32'h400) / 4;
    end else if (a >= ALIAS && a < ALIAS + 32'h2000) begin
      off = a - ALIAS; bank = int'(off / 32'h800); idx = int'(off % 32'h800) / 4;
    end else hit = 0;
  endfunction

  function automatic int phys(input int bank, input int idx);
    return (bank < 4) ? bank * 512 + idx : 2048 + (bank - 4) * 256 + idx;
  endfunction

  function automatic string wtag(input logic [31:0] a);
    if (a >= BASE && a < BASE + 32'h2000) return "R1";
    if (a >= SM0 && a < SM0 + 32'h800) return "R2";
    if (a >= ALIAS && a < ALIAS + 32'h2000) return "R3";
    return "R4";
  endfunction

  task automatic step();
    bit hit[2]; int bk[2]; int ix[2]; bit gnt[2]; bit taken[6]; bit conf;
    bit exp_rv[2]; bit exp_f[2]; logic [31:0] exp_d[2]; string tg[2];
    for (int m = 0; m < 2; m++) begin
      m_valid[m] = rq_v[m];
      m_addr[m*32 +: 32] = rq_a[m];
      m_we[m] = rq_we[m];
      m_be[m*4 +: 4] = rq_be[m];
      m_wdata[m*32 +: 32] = rq_wd[m];
      bdec(rq_a[m], hit[m], bk[m], ix[m]);
      gnt[m] = 0; exp_rv[m] = 0; exp_f[m] = 0; exp_d[m] = 0; tg[m] = wtag(rq_a[m]);
    end
    #1;
    for (int b = 0; b < 6; b++) begin
      int first = rr_m[b];
      taken[b] = 0;
      for (int k = 0; k < 2; k++) begin
        int m = (first + k) % 2;
        if (!taken[b] && rq_v[m] && hit[m] && bk[m] == b) begin
          taken[b] = 1; gnt[m] = 1; rr_m[b] = (m + 1) % 2;
        end
      end
    end
    for (int m = 0; m < 2; m++) if (rq_v[m] && !hit[m]) gnt[m] = 1;
    conf = rq_v[0] && rq_v[1] && hit[0] && hit[1] && bk[0] == bk[1];
    for (int m = 0; m < 2; m++)
      chk(m_ready[m] === gnt[m], conf ? "R7 R8" : (!rq_v[m] ? "R11" : (!hit[m] ? "R4" : "R5 R6")),
          32'(m_ready[m]), 32'(gnt[m]));
    for (int m = 0; m < 2; m++) if (gnt[m]) begin
      exp_rv[m] = !rq_we[m];
      exp_f[m]  = !hit[m];
      if (!rq_we[m] && hit[m]) exp_d[m] = mdl[phys(bk[m], ix[m])];
    end
    for (int m = 0; m < 2; m++) if (gnt[m] && rq_we[m] && hit[m]) begin
      for (int y = 0; y < 4; y++)
        if (rq_be[m][y]) mdl[phys(bk[m], ix[m])][y*8 +: 8] = rq_wd[m][y*8 +: 8];
    end
    for (int m = 0; m < 2; m++) if (gnt[m]) rq_v[m] = 0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(m_rvalid[m] === exp_rv[m], "R9", 32'(m_rvalid[m]), 32'(exp_rv[m]));
      chk(m_fault[m] === exp_f[m], "R4", 32'(m_fault[m]), 32'(exp_f[m]));
      if (exp_rv[m]) chk(m_rdata[m*32 +: 32] === exp_d[m], tg[m], m_rdata[m*32 +: 32], exp_d[m]);
      obs_d[m] = m_rdata[m*32 +: 32];
    end
  endtask

  task automatic arm(input int m, input logic [31:0] a, input bit we, input logic [3:0] be, input logic [31:0] wd);
    rq_v[m] = 1; rq_a[m] = a; rq_we[m] = we; rq_be[m] = be; rq_wd[m] = wd;
  endtask

  task automatic issue(input int m, input logic [31:0] a, input bit we, input logic [3:0] be, input logic [31:0] wd);
    arm(m, a, we, be, wd);
    while (rq_v[m]) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 6; b++) rr_m[b] = 0;
    for (int m = 0; m < 2; m++) begin rq_v[m] = 0; rq_a[m] = 0; rq_we[m] = 0; rq_be[m] = 0; rq_wd[m] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_ready === 2'b00, "R11", 32'(m_ready), 0);
    chk(m_rvalid === 2'b00, "R9", 32'(m_rvalid), 0);
    chk(m_fault === 2'b00, "R4", 32'(m_fault), 0);

    // preload: both masters in parallel on distinct banks (R6)
    for (int i = 0; i < 1024; i++) begin
      arm(0, BASE + 32'(2*i) * 4, 1, 4'hF, 32'hA500_0000 ^ 32'(2*i));
      arm(1, BASE + 32'(2*i+1) * 4, 1, 4'hF, 32'hA500_0000 ^ 32'(2*i+1));
      while (rq_v[0] || rq_v[1]) step();
    end
    for (int i = 0; i < 256; i++) begin
      arm(0, SM0 + 32'(i) * 4, 1, 4'hF, 32'h5A00_0000 ^ 32'(i));
      arm(1, SM0 + 32'h400 + 32'(i) * 4, 1, 4'hF, 32'h5B00_0000 ^ 32'(i));
      while (rq_v[0] || rq_v[1]) step();
    end

    // R1 R3: striped write, alias read (bank1 idx1)
    issue(0, BASE + 32'h14, 1, 4'hF, 32'hCAFE_0001);
    issue(1, ALIAS + 32'h800 + 32'h4, 0, 4'hF, 0);
    chk(obs_d[1] === 32'hCAFE_0001, "R1 R3", obs_d[1], 32'hCAFE_0001);
    // R3 R1: alias write bank2 idx5, striped read at offset 0x58
    issue(1, ALIAS + 32'h1000 + 32'h14, 1, 4'hF, 32'hBEEF_0205);
    issue(0, BASE + 32'h58, 0, 4'hF, 0);
    chk(obs_d[0] === 32'hBEEF_0205, "R3 R1", obs_d[0], 32'hBEEF_0205);
    // R2: last word of second small bank, low address bits ignored
    issue(0, SM0 + 32'h7FC, 1, 4'hF, 32'h0DD5_0FF5);
    issue(1, SM0 + 32'h7FE, 0, 4'hF, 0);
    chk(obs_d[1] === 32'h0DD5_0FF5, "R2", obs_d[1], 32'h0DD5_0FF5);
    // R10: byte strobes 0101
    issue(0, BASE + 32'h100, 1, 4'hF, 32'hFFFF_FFFF);
    issue(0, BASE + 32'h100, 1, 4'b0101, 32'h1234_5678);
    issue(1, BASE + 32'h100, 0, 4'hF, 0);
    chk(obs_d[1] === 32'hFF34_FF78, "R10", obs_d[1], 32'hFF34_FF78);
    // R4: faults just past each window edge, then storage unchanged
    issue(0, SM0 + 32'h800, 0, 4'hF, 0);
    chk(obs_d[0] === 32'h0, "R4", obs_d[0], 0);
    issue(1, ALIAS + 32'h2000, 1, 4'hF, 32'hDEAD_DEAD);
    issue(0, BASE - 32'h4, 1, 4'hF, 32'hDEAD_DEAD);
    issue(0, BASE + 32'h100, 0, 4'hF, 0);
    chk(obs_d[0] === 32'hFF34_FF78, "R4", obs_d[0], 32'hFF34_FF78);
    // R8: repeated conflicts on bank 3 alternate winners
    begin
      int w0;
      arm(0, BASE + 32'hC, 0, 4'hF, 0);
      arm(1, ALIAS + 32'h1800, 0, 4'hF, 0);
      step();
      w0 = rq_v[0] ? 1 : 0;
      arm(w0, (w0 == 0) ? BASE + 32'h1C : ALIAS + 32'h1804, 0, 4'hF, 0);
      step();
      chk(rq_v[1-w0] == 0 && rq_v[w0] == 1, "R8", 32'(1-w0), 32'(w0));
      while (rq_v[0] || rq_v[1]) step();
    end

    // constrained random phase
    for (int c = 0; c < 3000; c++) begin
      for (int m = 0; m < 2; m++) if (!rq_v[m] && ($urandom % 4) != 0) begin
        int r = $urandom % 16;
        logic [31:0] a;
        if (r < 6)       a = BASE + ($urandom % 32'h2000);
        else if (r < 9)  a = SM0 + ($urandom % 32'h800);
        else if (r < 14) a = ALIAS + ($urandom % 32'h2000);
        else case ($urandom % 4)
          0: a = BASE - 32'h4;
          1: a = SM0 + 32'h800;
          2: a = ALIAS + 32'h2000;
          default: a = $urandom;
        endcase
        if (m == 1 && rq_v[0] && ($urandom % 4) == 0) a = rq_a[0];
        arm(m, a, 1'($urandom % 2), 4'($urandom), $urandom);
      end
      step();
    end
    while (rq_v[0] || rq_v[1]) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule